// File: doc/BRIEF.md
# Twin-Predicated Vector Element Sequencer

This block walks the elements of one vector operation under two independent predicate masks: one picks which source elements are read, the other picks which destination elements are written. A start pulse captures the vector length, both masks with their inversion and "use every element" controls, and the starting source and destination steps. After that, each busy cycle issues one (source index, destination index) pair. For each pair, the byte-to-word sign extension of the addressed source element is written to the destination index.

Each step skips clear bits of its own mask, independently of the other. A single pass can therefore pack sparse sources into dense destinations, scatter dense sources into sparse destinations, or do both at once. The pass stops when either side runs out of elements below the vector length. The final step values are then left on the outputs, so a later pass can resume from them. Destination elements that are never written keep their old contents, because the block simply issues no write for them. Source data comes from an external register file, read combinationally through `src_idx`.

Top module: `twin_pred_seq`

## Requirements
- R1: After reset, `busy`, `done` and `wr_en` are low and both step outputs are zero.
- R2: The written word is the low byte of `src_data` with its bit 7 copied into every higher bit. Bits above bit 7 of `src_data` have no effect (0x…91 gives 0xFFFF_FFFF_FFFF_FF91).
- R3: The source step advances only to set bits of the effective source mask, and the destination step advances only to set bits of the effective destination mask, each on its own. Mask bit i governs element i.
- R4: When `src_inv` (`dst_inv`) is high, the complement of the supplied mask is the effective mask for that side.
- R5: When `src_all` (`dst_all`) is high, every element on that side is used, whatever the mask and the inversion control say.
- R6: The pass ends as soon as no set effective-mask bit remains below VL on either side, counted from that side's current step. No write is issued after that, so untouched destinations keep their values.
- R7: One transfer is issued per busy cycle. `done` is high for exactly one cycle, the busy cycle that follows the last transfer. A pass of N transfers keeps `busy` high for N+1 cycles.
- R8: Nonzero `srcstep_in`/`dststep_in` start each search at that element. Elements below the starting step are never used.
- R9: After `done`, each step output holds VL if its side was exhausted. Otherwise it holds the index of that side's next pending set bit. These values stay put until the next start.
- R10: With VL zero, or with a starting step at or above VL, the pass makes no transfer and raises `done` in its first busy cycle. A VL above MAXVL is treated as MAXVL.
- R11: `start` and every operand input are ignored while `busy` is high. Operands are captured only in the start cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a pass when idle |
| vl | input | SW | Vector length |
| src_mask | input | MAXVL | Source predicate bits |
| dst_mask | input | MAXVL | Destination predicate bits |
| src_inv | input | 1 | Invert source mask |
| dst_inv | input | 1 | Invert destination mask |
| src_all | input | 1 | Use every source element |
| dst_all | input | 1 | Use every destination element |
| srcstep_in | input | SW | Starting source step |
| dststep_in | input | SW | Starting destination step |
| src_data | input | XLEN | Source element addressed by src_idx |
| busy | output | 1 | Pass in progress |
| src_idx | output | SW | Source element being read |
| wr_en | output | 1 | Destination write this cycle |
| wr_idx | output | SW | Destination element written |
| wr_data | output | XLEN | Sign-extended byte to write |
| done | output | 1 | One-cycle end-of-pass pulse |
| srcstep_out | output | SW | Final or current source step |
| dststep_out | output | SW | Final or current destination step |

## Verification
The bench runs a small eight-element configuration. It sweeps every source mask against sixteen destination masks, with the vector length, the inversion and always controls, and the starting steps all varied alongside. This tells apart a sequencer that lets the two sides move independently from one that moves them in lockstep or shares one mask. Directed passes cover the pure compress, pure expand, mixed twin and mid-loop resume patterns, whose destination layouts differ only in where skipped elements fall. Zero-length and past-the-end starts separate an immediate finish from a spurious write. A pass hit with a second start and changed operands mid-run shows whether the operands were captured once.

// File: rtl/twin_pred_seq.sv
module twin_pred_seq #(
  parameter int MAXVL = 64,
  parameter int XLEN  = 64,
  localparam int SW   = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SW-1:0]    vl,
  input  logic [MAXVL-1:0] src_mask,
  input  logic [MAXVL-1:0] dst_mask,
  input  logic             src_inv,
  input  logic             dst_inv,
  input  logic             src_all,
  input  logic             dst_all,
  input  logic [SW-1:0]    srcstep_in,
  input  logic [SW-1:0]    dststep_in,
  input  logic [XLEN-1:0]  src_data,
  output logic             busy,
  output logic [SW-1:0]    src_idx,
  output logic             wr_en,
  output logic [SW-1:0]    wr_idx,
  output logic [XLEN-1:0]  wr_data,
  output logic             done,
  output logic [SW-1:0]    srcstep_out,
  output logic [SW-1:0]    dststep_out
);

  localparam logic [SW-1:0] MAXVL_C = SW'(MAXVL);

  logic             busy_q;
  logic [SW-1:0]    vl_q, ss_q, ds_q;
  logic [MAXVL-1:0] sm_q, dm_q;
  logic [SW-1:0]    ns, nd;
  logic             go;

  function automatic logic [SW-1:0] next_set(input logic [MAXVL-1:0] m,
                                             input logic [SW-1:0] from,
                                             input logic [SW-1:0] lim);
    logic [SW-1:0] r;
    r = lim;
    for (int i = MAXVL - 1; i >= 0; i--)
      if (m[i] && (i >= int'(from)) && (i < int'(lim)))
        r = SW'(i);
    return r;
  endfunction

  always_comb begin
    ns = next_set(sm_q, ss_q, vl_q);
    nd = next_set(dm_q, ds_q, vl_q);
  end

  assign go = busy_q && (ns != vl_q) && (nd != vl_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      vl_q   <= '0;
      ss_q   <= '0;
      ds_q   <= '0;
      sm_q   <= '0;
      dm_q   <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        vl_q   <= (vl > MAXVL_C) ? MAXVL_C : vl;
        sm_q   <= src_all ? '1 : (src_inv ? ~src_mask : src_mask);
        dm_q   <= dst_all ? '1 : (dst_inv ? ~dst_mask : dst_mask);
        ss_q   <= srcstep_in;
        ds_q   <= dststep_in;
      end
    end else if (go) begin
      ss_q <= ns + 1'b1;
      ds_q <= nd + 1'b1;
    end else begin
      busy_q <= 1'b0;
      ss_q   <= ns;
      ds_q   <= nd;
    end
  end

  assign busy        = busy_q;
  assign done        = busy_q && !go;
  assign wr_en       = go;
  assign src_idx     = ns;
  assign wr_idx      = nd;
  assign wr_data     = {{(XLEN-8){src_data[7]}}, src_data[7:0]};
  assign srcstep_out = ss_q;
  assign dststep_out = ds_q;

endmodule

module twin_pred_seq_chk #(
  parameter int SW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          wr_en,
  input logic [SW-1:0] src_idx,
  input logic [SW-1:0] wr_idx,
  input logic [SW-1:0] srcstep_out,
  input logic [SW-1:0] dststep_out
);

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  a_r7_write_in_pass: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (busy && !done));

  a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> ((wr_idx > $past(wr_idx)) && (src_idx > $past(src_idx))));

  a_r11_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r9_steps_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> ($stable(srcstep_out) && $stable(dststep_out)));

endmodule

bind twin_pred_seq twin_pred_seq_chk #(.SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .wr_en(wr_en), .src_idx(src_idx), .wr_idx(wr_idx),
  .srcstep_out(srcstep_out), .dststep_out(dststep_out)
);

// File: tb/twin_pred_seq_bench.sv
module twin_pred_seq_bench;
  localparam int MAXVL = 8;
  localparam int XLEN  = 64;
  localparam int SW    = $clog2(MAXVL + 1);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n, start, src_inv, dst_inv, src_all, dst_all;
  logic [SW-1:0]    vl, srcstep_in, dststep_in;
  logic [MAXVL-1:0] src_mask, dst_mask;
  logic [XLEN-1:0]  src_data;
  logic             busy, wr_en, done;
  logic [SW-1:0]    src_idx, wr_idx, srcstep_out, dststep_out;
  logic [XLEN-1:0]  wr_data;

  logic [XLEN-1:0] src_v [MAXVL];
  logic [XLEN-1:0] dreg  [MAXVL];
  logic [XLEN-1:0] expv  [MAXVL];
  int checks = 0, errors = 0, seed = 0;

  assign src_data = (int'(src_idx) < MAXVL) ? src_v[src_idx[2:0]] : '0;

  twin_pred_seq #(.MAXVL(MAXVL), .XLEN(XLEN)) u_twin_pred_seq (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] sext8(input logic [7:0] b);
    return {{56{b[7]}}, b};
  endfunction

  task automatic run_case(input int v, input logic [7:0] sm, input logic [7:0] dm,
                          input bit si, input bit di, input bit sa, input bit da,
                          input int ss, input int ds, input bit disturb, input string req);
    logic [7:0] esm, edm;
    int s, d, ecnt, cyc, n;
    bit fin, ok;
    esm = sa ? 8'hff : (si ? ~sm : sm);
    edm = da ? 8'hff : (di ? ~dm : dm);
    for (int i = 0; i < MAXVL; i++) begin
      src_v[i] = {56'h01_2345_6789_ABCD, 8'(seed * 29 + i * 73 + 8'h91)};
      dreg[i]  = 64'hA5A5_0000_0000_0000 | 64'(i);
      expv[i]  = dreg[i];
    end
    seed++;
    s = ss; d = ds; ecnt = 0;
    forever begin
      while (s < v && !esm[s]) s++;
      while (d < v && !edm[d]) d++;
      if (s >= v) s = v;
      if (d >= v) d = v;
      if (s >= v || d >= v) break;
      expv[d] = sext8(src_v[s][7:0]);
      s++; d++; ecnt++;
    end
    vl = SW'(v); src_mask = sm; dst_mask = dm;
    src_inv = si; dst_inv = di; src_all = sa; dst_all = da;
    srcstep_in = SW'(ss); dststep_in = SW'(ds);
    start = 1'b1;
    @(negedge clk);
    if (!disturb) start = 1'b0;
    else begin
      src_mask = ~sm; dst_mask = ~dm; vl = SW'(MAXVL);
      src_all = ~sa; srcstep_in = '0; dststep_in = '0;
    end
    cyc = 0; n = 0; fin = 0;
    for (int c = 0; c < 40; c++) begin
      cyc++;
      if (wr_en) begin
        n++;
        if (int'(wr_idx) < MAXVL) dreg[wr_idx[2:0]] = wr_data;
      end
      if (done) begin fin = 1; break; end
      @(negedge clk);
    end
    @(negedge clk);
    start = 1'b0;
    chk(fin, "R7", "done seen", 64'(fin), 64'd1);
    ok = 1;
    for (int i = 0; i < MAXVL; i++)
      if (dreg[i] !== expv[i]) begin
        ok = 0;
        chk(0, req, $sformatf("dst element %0d", i), dreg[i], expv[i]);
        break;
      end
    if (ok) chk(1, req, "dst contents", 0, 0);
    chk(srcstep_out == SW'(s), "R9", "final srcstep", 64'(srcstep_out), 64'(s));
    chk(dststep_out == SW'(d), "R9", "final dststep", 64'(dststep_out), 64'(d));
    chk(cyc == ecnt + 1 && n == ecnt, "R7", "busy cycles",
        64'(cyc), 64'(ecnt + 1));
    chk(!busy, "R11", "idle after pass", 64'(busy), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; vl = '0; src_mask = '0; dst_mask = '0;
    src_inv = 0; dst_inv = 0; src_all = 0; dst_all = 0;
    srcstep_in = '0; dststep_in = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !wr_en && srcstep_out == 0 && dststep_out == 0,
        "R1", "reset outputs", {busy, done, wr_en, srcstep_out, dststep_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4/R2: inverted source 0b10 -> 0b01, destination 0b10; element 1 gets byte 0x91
    run_case(2, 8'b10, 8'b10, 1, 0, 0, 0, 0, 0, 0, "R4");
    chk(dreg[1] == 64'hFFFF_FFFF_FFFF_FF91, "R2", "sign extension of 0x91",
        dreg[1], 64'hFFFF_FFFF_FFFF_FF91);
    chk(dreg[0] == 64'hA5A5_0000_0000_0000, "R6", "skipped dst kept", dreg[0],
        64'hA5A5_0000_0000_0000);
    // R3: compress and expand
    run_case(3, 8'b101, 8'b000, 0, 0, 0, 1, 0, 0, 0, "R3");
    run_case(3, 8'b000, 8'b101, 0, 0, 1, 0, 0, 0, 0, "R3");
    // R3: twin, source 0b101 with inverted destination 0b010
    run_case(3, 8'b101, 8'b101, 0, 1, 0, 0, 0, 0, 0, "R3");
    // R8: resume, only source 2 -> destination 3
    run_case(4, 8'b0101, 8'b0101, 0, 1, 0, 0, 1, 2, 0, "R8");
    chk(dreg[3] == sext8(src_v[2][7:0]) && dreg[2] == 64'hA5A5_0000_0000_0002,
        "R8", "resume transfer", dreg[3], sext8(src_v[2][7:0]));
    // R5: always overrides mask and inversion
    run_case(8, 8'h00, 8'hff, 1, 1, 1, 1, 0, 0, 0, "R5");
    // R10: zero length and start past the end
    run_case(0, 8'hff, 8'hff, 0, 0, 0, 0, 0, 0, 0, "R10");
    run_case(4, 8'hff, 8'hff, 0, 0, 0, 0, 5, 0, 0, "R10");
    run_case(4, 8'hff, 8'hff, 0, 0, 0, 0, 0, 4, 0, "R10");
    // R11: second start and changed operands mid-pass are ignored
    run_case(6, 8'b011010, 8'b110101, 0, 0, 0, 0, 0, 1, 1, "R11");
    // R6: sweep across masks, lengths, controls and steps
    for (int sm = 0; sm < 256; sm++)
      for (int k = 0; k < 16; k++)
        run_case((sm + k) % 9, 8'(sm), 8'(k * 29 + sm * 3), k[0], k[1],
                 k == 5, k == 10, (sm % 7 == 0) ? k % 4 : 0,
                 (k % 5 == 0) ? sm % 3 : 0, 0, "R6");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule